// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a register of parameterised width whose operation on each rising clock edge is picked by a two-bit mode code. The four operations are: keep the contents, load a parallel word, shift with a serial bit entering at the high end, or shift with a serial bit entering at the low end. Each shift direction has its own serial input. The contents are always visible on a parallel output, so the block can convert serial data to parallel and parallel data to serial, and it can rotate a word when its serial input is looped back from the opposite end.

Every bit has its own explicit multiplexer in front of its flip-flop. The multiplexer is driven by a decoded one-hot select, so that exactly one of four sources reaches each flip-flop. An active-low clear acts asynchronously, zeroes every bit and takes priority over any mode.

Top module: `univ_shift_reg`

## Requirements
- R1: While `clr_n` is low, `par_out` is all zeros. The clear takes effect as soon as `clr_n` falls, without waiting for a clock edge.
- R2: With mode code 2'b00, `par_out` keeps its value across a rising clock edge.
- R3: With mode code 2'b11, `par_out` takes the value of `par_in` at the rising clock edge.
- R4: With mode code 2'b10, bit WIDTH-1 takes `ser_in_hi` and each bit i below it takes the old bit i+1, so the data moves toward index 0.
- R5: With mode code 2'b01, bit 0 takes `ser_in_lo` and each bit i above it takes the old bit i-1, so the data moves toward index WIDTH-1.
- R6: Clear wins over every mode. A rising edge with `clr_n` low and mode 2'b11 leaves `par_out` at zero.
- R7: WIDTH shifts in mode 2'b01 with `ser_in_lo` fed from `par_out[WIDTH-1]` bring back the original word. The same holds for mode 2'b10 with `ser_in_hi` fed from `par_out[0]`.
- R8: Both serial inputs have no effect in modes 2'b00 and 2'b11. `par_in` has no effect in modes 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation code: 00 keep, 01 fill low end, 10 fill high end, 11 load |
| ser_in_hi | input | 1 | Serial bit that enters bit WIDTH-1 in mode 10 |
| ser_in_lo | input | 1 | Serial bit that enters bit 0 in mode 01 |
| par_in | input | WIDTH | Parallel word loaded in mode 11 |
| par_out | output | WIDTH | Current register contents |

## Verification
Each mode result is due one register stage later: the new value appears just after the rising edge that follows the cycle in which the mode and data were applied. The driver therefore applies inputs on a falling edge and queues the expected word for the next rising edge. The monitor pops and compares that word a short delay after the rising edge. The clear is the exception, because it has no clock stage. Its result is checked a delay step after `clr_n` falls, with no edge in between.

// File: rtl/usr_pkg.sv
package usr_pkg;

  // Mode codes; the encoding is fixed by the block's interface.
  typedef enum logic [1:0] {
    MODE_KEEP    = 2'b00,
    MODE_FILL_LO = 2'b01,
    MODE_FILL_HI = 2'b10,
    MODE_LOAD    = 2'b11
  } usr_mode_e;

  // One-hot source select shared by every bit multiplexer.
  typedef struct packed {
    logic load;
    logic from_above;
    logic from_below;
    logic keep;
  } usr_sel_t;

  localparam int unsigned SEL_COUNT = 4;

  // Decode a mode code into a one-hot select.
  function automatic usr_sel_t decode_mode(input logic [1:0] code);
    usr_sel_t s;
    s = '0;
    unique case (usr_mode_e'(code))
      MODE_KEEP:    s.keep       = 1'b1;
      MODE_FILL_LO: s.from_below = 1'b1;
      MODE_FILL_HI: s.from_above = 1'b1;
      MODE_LOAD:    s.load       = 1'b1;
      default:      s.keep       = 1'b1;
    endcase
    return s;
  endfunction

  // AND-OR selection of one bit from its four candidate sources.
  function automatic logic pick_bit(input usr_sel_t s, input logic keep_v,
                                    input logic below_v, input logic above_v,
                                    input logic load_v);
    return (s.keep & keep_v) | (s.from_below & below_v) |
           (s.from_above & above_v) | (s.load & load_v);
  endfunction

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic     clk,
  input  logic     clr_n,
  input  logic [1:0] mode,
  output usr_sel_t sel
);

  always_comb sel = decode_mode(mode);

  // R2 R3 R4 R5: exactly one source feeds the flip-flops on every active edge
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!clr_n)
    $countones({sel.load, sel.from_above, sel.from_below, sel.keep}) == 1)
    else $error("select vector not one-hot");

endmodule

// File: rtl/usr_bit_mux.sv
module usr_bit_mux
  import usr_pkg::*;
(
  input  usr_sel_t sel,
  input  logic     keep_v,
  input  logic     below_v,
  input  logic     above_v,
  input  logic     load_v,
  output logic     d
);

  always_comb d = pick_bit(sel, keep_v, below_v, above_v, load_v);

endmodule

// File: rtl/usr_flops.sv
module usr_flops #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode,
  input  logic             ser_in_hi,
  input  logic             ser_in_lo,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out
);

  localparam int unsigned MSB = WIDTH - 1;

  usr_sel_t         sel;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] nxt_d;
  // Neighbour taps, with the serial input filling the vacated end.
  logic [WIDTH-1:0] tap_above;
  logic [WIDTH-1:0] tap_below;
  // Named mode events, used by the assertions.
  logic op_keep, op_load, op_fill_hi, op_fill_lo;

  usr_mode_dec u_dec (
    .clk   (clk),
    .clr_n (clr_n),
    .mode  (mode),
    .sel   (sel)
  );

  assign tap_above = {ser_in_hi, cur_q[MSB:1]};
  assign tap_below = {cur_q[MSB-1:0], ser_in_lo};

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      usr_bit_mux u_mux (
        .sel     (sel),
        .keep_v  (cur_q[i]),
        .below_v (tap_below[i]),
        .above_v (tap_above[i]),
        .load_v  (par_in[i]),
        .d       (nxt_d[i])
      );
    end
  endgenerate

  usr_flops #(.WIDTH(WIDTH)) u_flops (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (nxt_d),
    .q     (cur_q)
  );

  assign par_out    = cur_q;
  assign op_keep    = (mode == 2'b00);
  assign op_fill_lo = (mode == 2'b01);
  assign op_fill_hi = (mode == 2'b10);
  assign op_load    = (mode == 2'b11);

  // R1 R6: clear holds every bit at zero
  p_clear_zero_r1: assert property (@(posedge clk)
    !clr_n |-> par_out == '0)
    else $error("contents not zero under clear");

  p_keep_r2: assert property (@(posedge clk) disable iff (!clr_n)
    op_keep |=> $stable(par_out))
    else $error("keep mode changed contents");

  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    op_load |=> par_out == $past(par_in))
    else $error("load mode wrong value");

  p_fill_hi_r4: assert property (@(posedge clk) disable iff (!clr_n)
    op_fill_hi |=> par_out == {$past(ser_in_hi), $past(par_out[MSB:1])})
    else $error("high-fill shift wrong value");

  p_fill_lo_r5: assert property (@(posedge clk) disable iff (!clr_n)
    op_fill_lo |=> par_out == {$past(par_out[MSB-1:0]), $past(ser_in_lo)})
    else $error("low-fill shift wrong value");

  initial begin
    p_width_r4: assert (WIDTH >= 2) else $error("WIDTH must be at least 2");
  end

endmodule

// File: tb/tb_univ_shift_reg.sv
module tb_univ_shift_reg;

  localparam int unsigned W      = 4;
  localparam time         PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         clr_n;
  logic [1:0]   mode;
  logic         ser_in_hi;
  logic         ser_in_lo;
  logic [W-1:0] par_in;
  logic [W-1:0] par_out;

  logic [W-1:0] model;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  int           n_checks = 0;
  int           n_fail   = 0;
  bit           done     = 1'b0;

  univ_shift_reg #(.WIDTH(W)) dut (
    .clk       (clk),
    .clr_n     (clr_n),
    .mode      (mode),
    .ser_in_hi (ser_in_hi),
    .ser_in_lo (ser_in_lo),
    .par_in    (par_in),
    .par_out   (par_out)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Driver: apply one operation on a falling edge, queue the result due
  // after the next rising edge.
  task automatic step(input logic [1:0] md, input logic hi, input logic lo,
                      input logic [W-1:0] din, input string tag);
    @(negedge clk);
    mode = md; ser_in_hi = hi; ser_in_lo = lo; par_in = din;
    case (md)
      2'b00: model = model;
      2'b01: model = {model[W-2:0], lo};
      2'b10: model = {hi, model[W-1:1]};
      default: model = din;
    endcase
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare after every rising edge that has a queued result.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(par_out, e, t);
    end
  end

  initial begin
    logic [W-1:0] saved;
    clr_n = 1'b0; mode = 2'b00; ser_in_hi = 1'b0; ser_in_lo = 1'b0;
    par_in = '0; model = '0;
    repeat (2) @(posedge clk);
    #1 check(par_out, '0, "R1 reset state");
    @(negedge clk); clr_n = 1'b1;

    // Load several patterns
    step(2'b11, 1'b0, 1'b0, 4'b1010, "R3 load 1010");
    step(2'b11, 1'b1, 1'b1, 4'b0110, "R3 R8 load ignores serial");
    step(2'b00, 1'b1, 1'b1, 4'b1111, "R2 R8 keep ignores all inputs");
    step(2'b00, 1'b0, 1'b0, 4'b0000, "R2 keep");
    // High-fill shifts
    step(2'b10, 1'b1, 1'b0, 4'b1111, "R4 R8 shift in 1 at top");
    step(2'b10, 1'b0, 1'b1, 4'b0000, "R4 shift in 0 at top");
    step(2'b10, 1'b1, 1'b0, 4'b0101, "R4 shift in 1 at top");
    // Low-fill shifts
    step(2'b01, 1'b0, 1'b1, 4'b1111, "R5 R8 shift in 1 at bottom");
    step(2'b01, 1'b1, 1'b0, 4'b0000, "R5 shift in 0 at bottom");
    step(2'b01, 1'b0, 1'b1, 4'b1001, "R5 shift in 1 at bottom");

    // Rotation through the low end
    step(2'b11, 1'b0, 1'b0, 4'b1101, "R3 load before rotate");
    saved = model;
    for (int i = 0; i < W; i++)
      step(2'b01, 1'b0, model[W-1], 4'b0011, "R7 rotate low-fill");
    @(posedge clk); #2 check(par_out, saved, "R7 low-fill rotation restores word");
    // Rotation through the high end
    for (int i = 0; i < W; i++)
      step(2'b10, model[0], 1'b0, 4'b1100, "R7 rotate high-fill");
    @(posedge clk); #2 check(par_out, saved, "R7 high-fill rotation restores word");

    // Asynchronous clear in mid-cycle, with load requested
    @(negedge clk);
    mode = 2'b11; par_in = 4'b1111; clr_n = 1'b0;
    #1 check(par_out, '0, "R1 async clear before edge");
    model = '0;
    exp_q.push_back('0); tag_q.push_back("R6 clear overrides load");
    @(negedge clk);
    clr_n = 1'b1; mode = 2'b00;
    exp_q.push_back('0); tag_q.push_back("R2 keep after clear");
    step(2'b10, 1'b1, 1'b0, 4'b0000, "R4 shift after clear");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule